// File: doc/BRIEF.md
# Memory Region Access Checker

This block sits in front of a memory target and decides, for each access, whether it may proceed. Each domain owns a small set of region descriptors. A descriptor gives an inclusive address window, a valid flag, a non-secure-only flag and a 3-bit index into a shared bank of eight 32-bit permission policies. A policy word holds one execute/write/read triple for each pairing of security state (secure or non-secure) with privilege level (user or privileged). An access carries its address, domain number, security state, privilege level and kind (read, write or instruction fetch). The block grants it when at least one valid descriptor of that domain covers the address and the selected policy allows the access.

Denied accesses are recorded in a single error record. The record holds the address, the domain, a 3-bit attribute code and a read/write flag. It also holds a state field that separates one violation from several. Later violations do not disturb the recorded fields; they only mark the record as multiple. Software clears the record through the register port. Enforcement starts once a sticky global enable bit has been set. Before that, every access is granted.

Top module: `mrc_region_checker`

## Requirements
- R1: After reset, all policies, descriptors, the global enable and the error record read as zero, and `rsp_valid` is low.
- R2: Writing 1 to bit 0 of word 0x00 sets the global enable, and only reset clears it; writing 0 has no effect. While the enable is clear, every access is granted and no error is recorded.
- R3: A descriptor covers an access when its valid bit is set, its domain matches `acc_did` and start ≤ address ≤ end, with both ends inclusive. With enforcement on, an access that no descriptor covers is denied.
- R4: The permission bit for an access is at position 8·(secure) + 4·(privileged) + offset, where the offset is 0 for execute, 1 for write and 2 for read. Kind codes are 0 read, 1 write, 2 execute, and 3 is treated as read. An access is granted if any covering descriptor's selected policy has this bit set.
- R5: A descriptor with its non-secure-only flag set denies every secure access. Non-secure accesses to it use the non-secure bits of its policy.
- R6: Policies are at words 0x08..0x0F. Once bit 31 of policy 0 is set, writes to policy 0 are ignored until reset. The other policies stay writable.
- R7: Each access presented with `acc_valid` gets `rsp_valid` high on the next clock, with the decision on `rsp_grant`.
- R8: The first denial while no error is pending sets the state to 2'b10 and records the address (word 0x01) and the error info (word 0x02). The info word holds state at [31:30], the write flag at [8] (1 for write; read and execute give 0), and the attribute at [6:4]. The attribute is {non-secure, privileged, not-execute}. The domain is at [3:0].
- R9: A denial while an error is pending sets the state to 2'b11 and leaves the recorded address, domain, attribute and write flag unchanged.
- R10: Writing word 0x02 with bit 31 set clears the state to 2'b00. If a denial arrives in the same cycle, it is recorded as a new single error.
- R11: Descriptor d·NREG+r occupies words 0x40+4·(d·NREG+r)+w. Word w=0 is the start, w=1 is the end, and w=2 is control: valid at [0], non-secure-only at [1], policy index at [6:4]. All three read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | 32 | Access address |
| acc_did | input | 2 | Domain of the access |
| acc_nonsec | input | 1 | 1 for a non-secure access |
| acc_priv | input | 1 | 1 for a privileged access |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Decision available for the previous cycle's request |
| rsp_grant | output | 1 | 1 grant, 0 deny |

## Verification
The bench hits both inclusive ends of a window and the address one past the end. A design with an off-by-one compare would deny the last byte or grant the byte after it. It sends a secure access to a non-secure-only region whose policy allows everything, which catches a flag that is ignored. It stacks violations to show that the second one must not overwrite the first record. It issues a clear in the same cycle as a new denial to show that the new error must not be lost. It also writes again to a locked policy, and in random traffic it varies the security/privilege/kind pairs so that a swapped group or offset shows up as a wrong decision.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

  typedef struct packed {
    logic [2:0] pol_sel;
    logic       nse;
    logic       valid;
  } rgn_ctl_t;

  localparam logic [1:0] EST_NONE   = 2'b00;
  localparam logic [1:0] EST_SINGLE = 2'b10;
  localparam logic [1:0] EST_MULTI  = 2'b11;

  localparam logic [1:0] KIND_WRITE = 2'd1;
  localparam logic [1:0] KIND_EXEC  = 2'd2;

  // group base: secure adds 8, privileged adds 4; offset X=0, W=1, R=2
  function automatic logic [3:0] perm_bit_index(input logic nonsec, input logic priv,
                                                input logic [1:0] kind);
    logic [1:0] off;
    if (kind == KIND_EXEC)       off = 2'd0;
    else if (kind == KIND_WRITE) off = 2'd1;
    else                         off = 2'd2;
    return {~nonsec, priv, off};
  endfunction

  function automatic logic [2:0] err_attr_code(input logic nonsec, input logic priv,
                                               input logic [1:0] kind);
    return {nonsec, priv, kind != KIND_EXEC};
  endfunction

  function automatic logic [1:0] next_err_state(input logic [1:0] cur, input logic viol,
                                                input logic clr);
    if (viol)      return (cur[1] && !clr) ? EST_MULTI : EST_SINGLE;
    else if (clr)  return EST_NONE;
    else           return cur;
  endfunction

endpackage

// File: rtl/mrc_policy_bank.sv
module mrc_policy_bank #(
  parameter int NPOL = 8,
  parameter int PW   = 32,
  localparam int IW  = $clog2(NPOL)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_idx,
  input  logic [PW-1:0]            wr_data,
  output logic [NPOL-1:0][PW-1:0]  pol_q,
  output logic                     lock0
);

  assign lock0 = pol_q[0][PW-1];

  logic wr_blocked;
  assign wr_blocked = wr_en && (wr_idx == '0) && lock0;

  for (genvar p = 0; p < NPOL; p++) begin : g_pol
    logic sel;
    assign sel = wr_en && (wr_idx == IW'(p)) && !(p == 0 && lock0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pol_q[p] <= '0;
      else if (sel) pol_q[p] <= wr_data;
    end
  end

  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    lock0 |=> $stable(pol_q[0])); // R6
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> lock0); // R6

endmodule

// File: rtl/mrc_region_file.sv
module mrc_region_file #(
  parameter int NENT = 16,
  parameter int AW   = 32,
  localparam int EW  = $clog2(NENT)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [EW-1:0]                     wr_ent,
  input  logic [1:0]                        wr_word,
  input  logic [31:0]                       wr_data,
  output logic [NENT-1:0][AW-1:0]           start_q,
  output logic [NENT-1:0][AW-1:0]           end_q,
  output mrc_pkg::rgn_ctl_t [NENT-1:0]      ctl_q
);

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    logic hit_ent;
    assign hit_ent = wr_en && (wr_ent == EW'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q[e] <= '0;
        end_q[e]   <= '0;
        ctl_q[e]   <= '0;
      end else if (hit_ent) begin
        case (wr_word)
          2'd0: start_q[e] <= wr_data[AW-1:0];
          2'd1: end_q[e]   <= wr_data[AW-1:0];
          2'd2: begin
            ctl_q[e].valid   <= wr_data[0];
            ctl_q[e].nse     <= wr_data[1];
            ctl_q[e].pol_sel <= wr_data[6:4];
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/mrc_region_match.sv
module mrc_region_match #(
  parameter int NDOM = 4,
  parameter int NREG = 4,
  parameter int AW   = 32,
  parameter int NPOL = 8,
  parameter int PW   = 32,
  localparam int DW   = $clog2(NDOM),
  localparam int NENT = NDOM * NREG,
  localparam int EW   = $clog2(NENT)
) (
  input  logic [AW-1:0]                 acc_addr,
  input  logic [DW-1:0]                 acc_did,
  input  logic                          acc_nonsec,
  input  logic                          acc_priv,
  input  logic [1:0]                    acc_kind,
  input  logic [NENT-1:0][AW-1:0]       start_q,
  input  logic [NENT-1:0][AW-1:0]       end_q,
  input  mrc_pkg::rgn_ctl_t [NENT-1:0]  ctl_q,
  input  logic [NPOL-1:0][PW-1:0]       pol_q,
  output logic                          any_hit,
  output logic                          grant
);

  function automatic logic region_hit(input logic [AW-1:0] a, input logic [AW-1:0] lo,
                                      input logic [AW-1:0] hi, input logic vld);
    return vld && (a >= lo) && (a <= hi);
  endfunction

  function automatic logic region_allows(input logic [PW-1:0] pol, input logic nse,
                                         input logic ns, input logic pv,
                                         input logic [1:0] kind);
    if (nse && !ns) return 1'b0;
    return pol[mrc_pkg::perm_bit_index(ns, pv, kind)];
  endfunction

  logic [NREG-1:0] hit_vec;
  logic [NREG-1:0] allow_vec;

  for (genvar r = 0; r < NREG; r++) begin : g_rgn
    logic [EW-1:0] ent;
    mrc_pkg::rgn_ctl_t c;
    assign ent = EW'(acc_did) * EW'(NREG) + EW'(r);
    assign c   = ctl_q[ent];
    assign hit_vec[r]   = region_hit(acc_addr, start_q[ent], end_q[ent], c.valid);
    assign allow_vec[r] = region_allows(pol_q[c.pol_sel], c.nse, acc_nonsec, acc_priv, acc_kind);
  end

  assign any_hit = |hit_vec;
  assign grant   = |(hit_vec & allow_vec);

endmodule

// File: rtl/mrc_err_capture.sv
module mrc_err_capture #(
  parameter int AW = 32,
  parameter int DW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          viol,
  input  logic          clr,
  input  logic [AW-1:0] f_addr,
  input  logic [DW-1:0] f_did,
  input  logic [2:0]    f_attr,
  input  logic          f_rw,
  output logic [1:0]    est_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] did_q,
  output logic [2:0]    attr_q,
  output logic          rw_q
);
  import mrc_pkg::*;

  logic pending;
  logic capture_new;
  assign pending     = est_q[1];
  assign capture_new = viol && (!pending || clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est_q  <= EST_NONE;
      addr_q <= '0;
      did_q  <= '0;
      attr_q <= '0;
      rw_q   <= 1'b0;
    end else begin
      est_q <= next_err_state(est_q, viol, clr);
      if (capture_new) begin
        addr_q <= f_addr;
        did_q  <= f_did;
        attr_q <= f_attr;
        rw_q   <= f_rw;
      end
    end
  end

  AST_FIRST_IS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !pending) |=> (est_q == EST_SINGLE)); // R8
  AST_LATER_KEEPS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && pending && !clr) |=> (est_q == EST_MULTI) && $stable(addr_q) && $stable(did_q)); // R9
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !viol) |=> (est_q == EST_NONE)); // R10
  AST_CLEAR_VIOL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && viol) |=> (est_q == EST_SINGLE) && (addr_q == $past(f_addr))); // R10

endmodule

// File: rtl/mrc_region_checker.sv
module mrc_region_checker #(
  parameter int NDOM = 4,
  parameter int NREG = 4,
  parameter int AW   = 32,
  parameter int NPOL = 8,
  parameter int RAW  = 8,
  localparam int DW   = $clog2(NDOM)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           acc_valid,
  input  logic [AW-1:0]  acc_addr,
  input  logic [DW-1:0]  acc_did,
  input  logic           acc_nonsec,
  input  logic           acc_priv,
  input  logic [1:0]     acc_kind,
  output logic           rsp_valid,
  output logic           rsp_grant
);
  import mrc_pkg::*;

  localparam int NENT = NDOM * NREG;
  localparam int EW   = $clog2(NENT);
  localparam int PIW  = $clog2(NPOL);
  localparam logic [RAW-1:0] CTRL_WA     = RAW'(0);
  localparam logic [RAW-1:0] ERR_ADDR_WA = RAW'(1);
  localparam logic [RAW-1:0] ERR_INFO_WA = RAW'(2);
  localparam logic [RAW-1:0] POL_WA      = RAW'(8);
  localparam logic [RAW-1:0] DESC_WA     = RAW'(64);
  localparam logic [RAW-1:0] DESC_SPAN   = RAW'(4 * NENT);

  // register decode
  logic [RAW-1:0] pol_off, desc_off;
  logic           in_pol, in_desc;
  logic           wr_ctrl, wr_pol, wr_desc, err_clr;
  logic [PIW-1:0] pol_idx;
  logic [EW-1:0]  desc_ent;
  logic [1:0]     desc_word;

  assign pol_off   = reg_addr - POL_WA;
  assign desc_off  = reg_addr - DESC_WA;
  assign in_pol    = (reg_addr >= POL_WA) && (pol_off < RAW'(NPOL));
  assign in_desc   = (reg_addr >= DESC_WA) && (desc_off < DESC_SPAN);
  assign pol_idx   = pol_off[PIW-1:0];
  assign desc_ent  = desc_off[EW+1:2];
  assign desc_word = desc_off[1:0];
  assign wr_ctrl   = reg_we && (reg_addr == CTRL_WA);
  assign wr_pol    = reg_we && in_pol;
  assign wr_desc   = reg_we && in_desc;
  assign err_clr   = reg_we && (reg_addr == ERR_INFO_WA) && reg_wdata[31];

  // sticky global enable
  logic gbl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       gbl_q <= 1'b0;
    else if (wr_ctrl && reg_wdata[0]) gbl_q <= 1'b1;
  end

  logic [NPOL-1:0][31:0]   pol_q;
  logic                    lock0;
  logic [NENT-1:0][AW-1:0] start_q, end_q;
  rgn_ctl_t [NENT-1:0]     ctl_q;

  mrc_policy_bank #(.NPOL(NPOL), .PW(32)) u_pol (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_pol), .wr_idx(pol_idx),
    .wr_data(reg_wdata), .pol_q(pol_q), .lock0(lock0)
  );

  mrc_region_file #(.NENT(NENT), .AW(AW)) u_rgn (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_desc), .wr_ent(desc_ent),
    .wr_word(desc_word), .wr_data(reg_wdata),
    .start_q(start_q), .end_q(end_q), .ctl_q(ctl_q)
  );

  logic any_hit, match_grant;
  mrc_region_match #(.NDOM(NDOM), .NREG(NREG), .AW(AW), .NPOL(NPOL), .PW(32)) u_match (
    .acc_addr(acc_addr), .acc_did(acc_did), .acc_nonsec(acc_nonsec),
    .acc_priv(acc_priv), .acc_kind(acc_kind),
    .start_q(start_q), .end_q(end_q), .ctl_q(ctl_q), .pol_q(pol_q),
    .any_hit(any_hit), .grant(match_grant)
  );

  // decision and violation event
  logic decide_grant, viol;
  assign decide_grant = !gbl_q || match_grant;
  assign viol         = acc_valid && !decide_grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_grant <= acc_valid && decide_grant;
    end
  end

  logic [1:0]    est_q;
  logic [AW-1:0] eaddr_q;
  logic [DW-1:0] edid_q;
  logic [2:0]    eattr_q;
  logic          erw_q;

  mrc_err_capture #(.AW(AW), .DW(DW)) u_err (
    .clk(clk), .rst_n(rst_n), .viol(viol), .clr(err_clr),
    .f_addr(acc_addr), .f_did(acc_did),
    .f_attr(err_attr_code(acc_nonsec, acc_priv, acc_kind)),
    .f_rw(acc_kind == KIND_WRITE),
    .est_q(est_q), .addr_q(eaddr_q), .did_q(edid_q), .attr_q(eattr_q), .rw_q(erw_q)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_WA)          reg_rdata = {31'b0, gbl_q};
    else if (reg_addr == ERR_ADDR_WA) reg_rdata = 32'(eaddr_q);
    else if (reg_addr == ERR_INFO_WA) reg_rdata = {est_q, 21'b0, erw_q, 1'b0, eattr_q, 4'(edid_q)};
    else if (in_pol)                  reg_rdata = pol_q[pol_idx];
    else if (in_desc) begin
      case (desc_word)
        2'd0:    reg_rdata = 32'(start_q[desc_ent]);
        2'd1:    reg_rdata = 32'(end_q[desc_ent]);
        2'd2:    reg_rdata = {25'b0, ctl_q[desc_ent].pol_sel, 2'b00,
                              ctl_q[desc_ent].nse, ctl_q[desc_ent].valid};
        default: reg_rdata = '0;
      endcase
    end
  end

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid); // R7
  AST_NO_HIT_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && gbl_q && !any_hit) |=> !rsp_grant); // R3
  AST_GBL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    gbl_q |=> gbl_q); // R2
  AST_OPEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !gbl_q) |=> rsp_grant); // R2

endmodule

// File: tb/mrc_region_checker_bench.sv
`timescale 1ns/1ps
module mrc_region_checker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_did = '0;
  logic        acc_nonsec = 1'b0;
  logic        acc_priv = 1'b0;
  logic [1:0]  acc_kind = '0;
  logic        rsp_valid, rsp_grant;

  always #2.5 clk = ~clk;

  mrc_region_checker u_mrc_region_checker (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_did(acc_did), .acc_nonsec(acc_nonsec),
    .acc_priv(acc_priv), .acc_kind(acc_kind), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model
  logic [31:0] m_pol [8];
  logic [31:0] m_lo [16];
  logic [31:0] m_hi [16];
  bit          m_valid [16];
  bit          m_nse [16];
  logic [2:0]  m_sel [16];
  bit          m_gbl;
  logic [1:0]  m_est;
  logic [31:0] m_eaddr;
  logic [1:0]  m_edid;
  logic [2:0]  m_eattr;
  bit          m_erw;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic bit exp_allow(int e, bit ns, bit pv, logic [1:0] kind);
    int group, off;
    if (m_nse[e] && !ns) return 0;
    group = ns ? (pv ? 4 : 0) : (pv ? 12 : 8);
    off = (kind == 2'd2) ? 0 : (kind == 2'd1) ? 1 : 2;
    return m_pol[m_sel[e]][group + off];
  endfunction

  function automatic bit exp_grant(logic [31:0] a, logic [1:0] did, bit ns, bit pv, logic [1:0] kind);
    if (!m_gbl) return 1;
    for (int r = 0; r < 4; r++) begin
      int e = int'(did) * 4 + r;
      if (m_valid[e] && m_lo[e] <= a && a <= m_hi[e] && exp_allow(e, ns, pv, kind)) return 1;
    end
    return 0;
  endfunction

  function automatic logic [31:0] exp_info();
    return {m_est, 21'b0, m_erw, 1'b0, m_eattr, 2'b00, m_edid};
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    if (a == 8'd0 && d[0]) m_gbl = 1;
    if (a == 8'd2 && d[31]) m_est = 2'b00;
    if (a >= 8'd8 && a < 8'd16) begin
      int p = int'(a) - 8;
      if (!(p == 0 && m_pol[0][31])) m_pol[p] = d;
    end
    if (a >= 8'd64 && a < 8'd128) begin
      int e = (int'(a) - 64) >> 2;
      case (a[1:0])
        2'd0: m_lo[e] = d;
        2'd1: m_hi[e] = d;
        2'd2: begin m_valid[e] = d[0]; m_nse[e] = d[1]; m_sel[e] = d[6:4]; end
        default: ;
      endcase
    end
  endtask

  task automatic model_viol(input logic [31:0] a, input logic [1:0] did, input bit ns,
                            input bit pv, input logic [1:0] kind, input bit clr);
    if (m_est[1] && !clr) m_est = 2'b11;
    else begin
      m_est = 2'b10; m_eaddr = a; m_edid = did;
      m_eattr = {ns, pv, kind != 2'd2}; m_erw = (kind == 2'd1);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic check_err(input string req);
    logic [31:0] v;
    reg_rd(8'd2, v);
    check(v == exp_info(), {req, " error info"}, v, exp_info());
    if (m_est[1]) begin
      reg_rd(8'd1, v);
      check(v == m_eaddr, {req, " error address"}, v, m_eaddr);
    end
  endtask

  // one access; optionally a clear of the error record in the same cycle
  task automatic access(input logic [31:0] a, input logic [1:0] did, input bit ns, input bit pv,
                        input logic [1:0] kind, input bit clr, input string req);
    bit g;
    g = exp_grant(a, did, ns, pv, kind);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_did = did; acc_nonsec = ns; acc_priv = pv; acc_kind = kind;
    if (clr) begin reg_we = 1'b1; reg_addr = 8'd2; reg_wdata = 32'h8000_0000; end
    @(negedge clk);
    acc_valid = 1'b0; reg_we = 1'b0;
    check(rsp_valid == 1'b1, "R7 rsp_valid", 32'(rsp_valid), 32'd1);
    check(rsp_grant == g, {req, " grant"}, 32'(rsp_grant), 32'(g));
    if (clr) m_est = 2'b00;
    if (!g) model_viol(a, did, ns, pv, kind, clr);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd24611));
    for (int i = 0; i < 8; i++) m_pol[i] = '0;
    for (int i = 0; i < 16; i++) begin
      m_lo[i] = '0; m_hi[i] = '0; m_valid[i] = 0; m_nse[i] = 0; m_sel[i] = '0;
    end
    m_gbl = 0; m_est = '0; m_eaddr = '0; m_edid = '0; m_eattr = '0; m_erw = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
    reg_rd(8'd0, v);  check(v == 0, "R1 control", v, 0);
    reg_rd(8'd2, v);  check(v == 0, "R1 error info", v, 0);
    reg_rd(8'd11, v); check(v == 0, "R1 policy 3", v, 0);
    reg_rd(8'd70, v); check(v == 0, "R1 descriptor ctl", v, 0);

    // R2 open while disabled
    access(32'h0000_1234, 2'd0, 0, 0, 2'd0, 0, "R2 disabled");
    check_err("R2 no capture");
    reg_wr(8'd0, 32'd1);
    reg_wr(8'd0, 32'd0);
    reg_rd(8'd0, v); check(v == 1, "R2 sticky enable", v, 1);

    // R11 descriptor for domain 1 region 0 (entry 4): 0x100..0x1FF, policy 2
    reg_wr(8'd80, 32'h100);
    reg_wr(8'd81, 32'h1FF);
    reg_wr(8'd82, 32'h21);
    reg_wr(8'd10, 32'h0000_0402); // secure user read + non-secure user write
    reg_rd(8'd80, v); check(v == 32'h100, "R11 start", v, 32'h100);
    reg_rd(8'd81, v); check(v == 32'h1FF, "R11 end", v, 32'h1FF);
    reg_rd(8'd82, v); check(v == 32'h21, "R11 ctl", v, 32'h21);

    // R3 inclusive edges
    access(32'h100, 2'd1, 0, 0, 2'd0, 0, "R3 low edge");
    access(32'h1FF, 2'd1, 0, 0, 2'd0, 0, "R3 high edge");
    access(32'h200, 2'd1, 0, 0, 2'd0, 0, "R3 past end");
    check_err("R8 first violation");
    // R4 group/offset
    access(32'h150, 2'd1, 0, 1, 2'd0, 0, "R4 secure priv read");
    check_err("R9 second violation");
    access(32'h150, 2'd1, 1, 0, 2'd1, 0, "R4 nonsec user write");
    access(32'h150, 2'd0, 0, 0, 2'd0, 0, "R3 other domain");
    check_err("R9 multiple");
    reg_wr(8'd2, 32'h8000_0000);
    check_err("R10 clear");
    access(32'h150, 2'd1, 1, 1, 2'd2, 0, "R4 nonsec priv exec");
    check_err("R8 attribute");

    // R5 non-secure-only region, all-permitting policy 3
    reg_wr(8'd11, 32'h0000_FFFF);
    reg_wr(8'd84, 32'h300);
    reg_wr(8'd85, 32'h3FF);
    reg_wr(8'd86, 32'h33);
    access(32'h310, 2'd1, 0, 1, 2'd0, 1, "R5 secure denied");
    check_err("R10 clear with violation");
    access(32'h310, 2'd1, 1, 1, 2'd0, 0, "R5 nonsec granted");

    // R6 lock
    reg_wr(8'd8, 32'h8000_0001);
    reg_wr(8'd8, 32'h0000_0000);
    reg_rd(8'd8, v); check(v == 32'h8000_0001, "R6 locked policy", v, 32'h8000_0001);
    reg_wr(8'd9, 32'h0000_1234);
    reg_rd(8'd9, v); check(v == 32'h1234, "R6 other policy", v, 32'h1234);

    // random traffic
    for (int it = 0; it < 600; it++) begin
      int op = int'($urandom_range(0, 99));
      if (op < 10) begin
        int e = int'($urandom_range(0, 15));
        logic [31:0] lo = 32'($urandom_range(0, 32'h3FF));
        reg_wr(8'(64 + 4 * e), lo);
        reg_wr(8'(65 + 4 * e), lo + 32'($urandom_range(0, 32'hFF)));
        reg_wr(8'(66 + 4 * e), {25'b0, 3'($urandom_range(0, 7)), 2'b00,
                                1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0)});
      end else if (op < 15) begin
        reg_wr(8'(8 + $urandom_range(0, 7)), $urandom());
      end else if (op < 20) begin
        reg_wr(8'd2, 32'h8000_0000);
      end else begin
        access(32'($urandom_range(0, 32'h4FF)), 2'($urandom_range(0, 3)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               2'($urandom_range(0, 3)), ($urandom_range(0, 19) == 0), "R4 random");
        check_err("R9 random record");
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule